// File: doc/BRIEF.md
# Sleep-Aware Watchdog Timer

This block guards a small processor core against runaway firmware. It is clocked by a free-running low-frequency clock, nominally 31 kHz. A tick divider turns that clock into roughly 1 ms ticks. A tick counter then compares its count against a power-of-two limit chosen by a software-written period select. A two-bit configuration field decides when the watchdog runs: always, only while the core is awake, only when a software enable bit is set, or never.

Firmware clears the counter with a clear-instruction strobe. The counter also restarts when the core goes to sleep, when it leaves sleep, when the oscillator is reported failed, and whenever the watchdog is disabled. When the limit is reached while the core is awake, the block issues a one-cycle reset request. When the limit is reached while the core sleeps, the block issues a one-cycle wake request instead and takes itself out of the sleep state. Two active-low status flags record the cause for firmware: one for a time-out and one for power-down. All strobes are assumed to be already synchronous to the low-frequency clock.

Top module: `wdog_ctrl`

## Requirements
- R1: A tick is produced once every DIV_COUNT enabled clocks. With period select n, the reset request rises exactly DIV_COUNT*2^n clocks after the last clock at which the counter was cleared.
- R2: After reset, rst_req and wake_req are 0 and to_n and pd_n are 1. The period select holds PS_RESET (default 11, i.e. 2048 ticks) until it is loaded.
- R3: A period select value above PS_MAX (default 18) behaves exactly as PS_MAX.
- R4: The mode field enables counting as follows: 2'b11 always, 2'b10 only while awake, 2'b01 only while sw_en is 1, and 2'b00 never. While disabled, no request is produced and the count is held at zero.
- R5: Each of the following restarts the count from zero: clr_wdt, sleep_enter, sleep_exit, and osc_fail.
- R6: A time-out while awake raises rst_req for exactly one clock and drives to_n to 0 at the same clock edge.
- R7: A time-out while asleep raises wake_req for one clock instead of rst_req, drives to_n to 0, and leaves the sleep state. Counting then continues as awake from zero.
- R8: sleep_enter drives pd_n to 0 at the next edge. clr_wdt without sleep_enter sets both to_n and pd_n to 1. When both strobes arrive in the same clock, pd_n goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency watchdog clock |
| rst_n | input | 1 | Active-low system reset |
| mode | input | 2 | Run-mode configuration field |
| sw_en | input | 1 | Software enable, used in mode 2'b01 |
| ps_load | input | 1 | Load strobe for the period select |
| ps_data | input | PS_W | New period select value |
| clr_wdt | input | 1 | Clear-instruction strobe |
| sleep_enter | input | 1 | Core is entering sleep |
| sleep_exit | input | 1 | Core is leaving sleep |
| osc_fail | input | 1 | Oscillator failure flag |
| rst_req | output | 1 | One-clock reset request (awake time-out) |
| wake_req | output | 1 | One-clock wake request (asleep time-out) |
| to_n | output | 1 | Time-out status, active low |
| pd_n | output | 1 | Power-down status, active low |

## Verification
The bench measures the exact clock of each time-out relative to the last clear. A divider that is off by one shifts the request by one clock for every tick, and a counter compare that is off by one doubles or halves the period. A clear event that arrives shortly before the limit must push the request out by a full period; a design that ignores sleep exit or oscillator failure would fire at the original time. A period select of 31 must act as the ceiling value; an unclamped or truncated select would fire at the wrong power of two. Sleep is checked in two modes. In mode 2'b10, a design that keeps counting would reset a sleeping core. In mode 2'b11, a design that raises a reset instead of a wake, or that stays asleep afterwards, shows up on the next awake period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      WDM_OFF    = 2'b00,
      WDM_SOFT   = 2'b01,
      WDM_AWAKE  = 2'b10,
      WDM_ALWAYS = 2'b11
   } wdt_mode_e;

   // Decide whether counting is permitted for a given mode and core state
   function automatic logic wdt_run(input logic [1:0] mode, input logic asleep,
                                    input logic sw_en);
      unique case (wdt_mode_e'(mode))
         WDM_ALWAYS: wdt_run = 1'b1;
         WDM_AWAKE:  wdt_run = ~asleep;
         WDM_SOFT:   wdt_run = sw_en;
         default:    wdt_run = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
   parameter int DIV_COUNT = 31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int DW   = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
   localparam bit POW2 = ((DIV_COUNT & (DIV_COUNT - 1)) == 0);
   localparam logic [DW-1:0] LAST = DW'(DIV_COUNT - 1);

   logic [DW-1:0] div_q;

   generate
      if (POW2) begin : g_wrap
         // Power-of-two ratio: the counter wraps by itself
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     div_q <= '0;
            else if (clr)   div_q <= '0;
            else if (en)    div_q <= div_q + 1'b1;
         end
         assign tick = en & (&div_q);
      end else begin : g_cmp
         // Arbitrary ratio: compare against the terminal value
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     div_q <= '0;
            else if (clr)   div_q <= '0;
            else if (en)    div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
         end
         assign tick = en & (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdt_period_cnt.sv
module wdt_period_cnt #(
   parameter int PS_W     = 5,
   parameter int PS_MAX   = 18,
   parameter int PS_RESET = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ps_load,
   input  logic [PS_W-1:0] ps_data,
   input  logic            clr,
   input  logic            tick,
   output logic            expire
);
   localparam int CW = (PS_MAX > 0) ? PS_MAX : 1;
   localparam logic [PS_W-1:0] SEL_CAP = PS_W'(PS_MAX);

   logic [PS_W-1:0] ps_q;
   logic [PS_W-1:0] sel_eff;
   logic [CW-1:0]   cnt_q;
   logic [CW-1:0]   mask;
   logic            hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ps_q <= PS_W'(PS_RESET);
      else if (ps_load) ps_q <= ps_data;
   end

   assign sel_eff = (ps_q > SEL_CAP) ? SEL_CAP : ps_q;
   // 2^n - 1; when n equals the width the shift empties and the subtraction wraps
   assign mask    = ({{(CW-1){1'b0}}, 1'b1} << sel_eff) - 1'b1;
   assign hit     = (cnt_q == mask);
   assign expire  = tick & hit & ~clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (tick)     cnt_q <= hit ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdt_sleep_status.sv
module wdt_sleep_status (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_enter,
   input  logic sleep_exit,
   input  logic clr_wdt,
   input  logic expire,
   output logic asleep,
   output logic rst_req,
   output logic wake_req,
   output logic to_n,
   output logic pd_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep   <= 1'b0;
         rst_req  <= 1'b0;
         wake_req <= 1'b0;
         to_n     <= 1'b1;
         pd_n     <= 1'b1;
      end else begin
         rst_req  <= expire & ~asleep;
         wake_req <= expire & asleep;

         if (sleep_enter)                        asleep <= 1'b1;
         else if (sleep_exit | (expire & asleep)) asleep <= 1'b0;

         if (expire)       to_n <= 1'b0;
         else if (clr_wdt) to_n <= 1'b1;

         if (sleep_enter)  pd_n <= 1'b0;
         else if (clr_wdt) pd_n <= 1'b1;
      end
   end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
   parameter int DIV_COUNT = 31,
   parameter int PS_W      = 5,
   parameter int PS_MAX    = 18,
   parameter int PS_RESET  = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      mode,
   input  logic            sw_en,
   input  logic            ps_load,
   input  logic [PS_W-1:0] ps_data,
   input  logic            clr_wdt,
   input  logic            sleep_enter,
   input  logic            sleep_exit,
   input  logic            osc_fail,
   output logic            rst_req,
   output logic            wake_req,
   output logic            to_n,
   output logic            pd_n
);
   import wdt_pkg::*;

   generate
      if (DIV_COUNT < 2) begin : g_bad_div
         $error("wdog_ctrl: DIV_COUNT must be at least 2");
      end
      if (PS_MAX < 1 || PS_MAX >= (1 << PS_W)) begin : g_bad_max
         $error("wdog_ctrl: PS_MAX must be in 1 .. 2**PS_W-1");
      end
      if (PS_RESET > PS_MAX) begin : g_bad_rst
         $error("wdog_ctrl: PS_RESET must not exceed PS_MAX");
      end
   endgenerate

   logic asleep;
   logic run;
   logic clr_all;
   logic cnt_en;
   logic tick;
   logic expire;

   assign run     = wdt_run(mode, asleep, sw_en);
   assign clr_all = ~run | clr_wdt | sleep_enter | sleep_exit | osc_fail;
   assign cnt_en  = run & ~clr_all;

   wdt_tick_div #(.DIV_COUNT(DIV_COUNT)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_all),
      .en    (cnt_en),
      .tick  (tick)
   );

   wdt_period_cnt #(.PS_W(PS_W), .PS_MAX(PS_MAX), .PS_RESET(PS_RESET)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ps_load (ps_load),
      .ps_data (ps_data),
      .clr     (clr_all),
      .tick    (tick),
      .expire  (expire)
   );

   wdt_sleep_status u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_enter (sleep_enter),
      .sleep_exit  (sleep_exit),
      .clr_wdt     (clr_wdt),
      .expire      (expire),
      .asleep      (asleep),
      .rst_req     (rst_req),
      .wake_req    (wake_req),
      .to_n        (to_n),
      .pd_n        (pd_n)
   );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic       clr_wdt,
   input logic       sleep_enter,
   input logic       osc_fail,
   input logic       asleep,
   input logic       rst_req,
   input logic       wake_req,
   input logic       to_n,
   input logic       pd_n
);
   a_r6_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   a_r6_to_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(to_n) |-> (rst_req || wake_req));

   a_r7_wake_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && wake_req));

   a_r7_wake_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> ($past(asleep) && !asleep));

   a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> (!rst_req && !wake_req));

   a_r5_oscfail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      osc_fail |=> (!rst_req && !wake_req));

   a_r8_enter_pd: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_enter |=> (!pd_n && asleep));

   a_r8_clr_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wdt && !sleep_enter) |=> (to_n && pd_n));
endmodule

bind wdog_ctrl wdt_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode        (mode),
   .clr_wdt     (clr_wdt),
   .sleep_enter (sleep_enter),
   .osc_fail    (osc_fail),
   .asleep      (asleep),
   .rst_req     (rst_req),
   .wake_req    (wake_req),
   .to_n        (to_n),
   .pd_n        (pd_n)
);

// File: tb/wdog_ctrl_bench.sv
module wdog_ctrl_bench;
   localparam int DIV = 31;
   localparam int PW  = 5;
   localparam int PMX = 6;
   localparam int PRS = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'b11;
   logic          sw_en = 1'b0;
   logic          ps_load = 1'b0;
   logic [PW-1:0] ps_data = '0;
   logic          clr_wdt = 1'b0;
   logic          sleep_enter = 1'b0;
   logic          sleep_exit = 1'b0;
   logic          osc_fail = 1'b0;
   logic          rst_req, wake_req, to_n, pd_n;

   wdog_ctrl #(.DIV_COUNT(DIV), .PS_W(PW), .PS_MAX(PMX), .PS_RESET(PRS)) u_wdog_ctrl (
      .clk(clk), .rst_n(rst_n), .mode(mode), .sw_en(sw_en),
      .ps_load(ps_load), .ps_data(ps_data), .clr_wdt(clr_wdt),
      .sleep_enter(sleep_enter), .sleep_exit(sleep_exit), .osc_fail(osc_fail),
      .rst_req(rst_req), .wake_req(wake_req), .to_n(to_n), .pd_n(pd_n)
   );

   always #5 clk = ~clk;

   // 0 = rst_req, 1 = wake_req, 2 = to_n, 3 = pd_n
   typedef struct {
      int    cyc;
      int    sig;
      logic  val;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_at(input int c, input int s, input logic v, input string r);
      exp_t it;
      int   pos;
      it.cyc = c; it.sig = s; it.val = v; it.req = r;
      pos = exp_q.size();
      for (int i = 0; i < exp_q.size(); i++) begin
         if (exp_q[i].cyc > c) begin pos = i; break; end
      end
      exp_q.insert(pos, it);
   endtask

   // Monitor: compare queued expectations away from the active edge
   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
         exp_t it;
         logic act;
         it = exp_q.pop_front();
         case (it.sig)
            0: act = rst_req;
            1: act = wake_req;
            2: act = to_n;
            default: act = pd_n;
         endcase
         n_chk++;
         if (it.cyc != cyc || act !== it.val) begin
            n_fail++;
            $display("FAIL %s cycle %0d sig %0d actual %b expected %b (at %0d)",
                     it.req, it.cyc, it.sig, act, it.val, cyc);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) step(1);
   endtask

   task automatic expect_timeout(input int e0, input int n, input string r);
      expect_at(e0 + n - 1, 0, 1'b0, r);
      expect_at(e0 + n,     0, 1'b1, r);
      expect_at(e0 + n,     2, 1'b0, r);
      expect_at(e0 + n + 1, 0, 1'b0, r);
   endtask

   task automatic load_ps(input int v);
      ps_data = PW'(v); ps_load = 1'b1; step(1); ps_load = 1'b0;
   endtask

   task automatic do_clr();
      clr_wdt = 1'b1; step(1); clr_wdt = 1'b0;
   endtask

   initial begin
      int e0, e1;
      step(3);
      rst_n = 1'b1;
      // R2: state right after reset
      expect_at(cyc + 1, 0, 1'b0, "R2 rst_req");
      expect_at(cyc + 1, 1, 1'b0, "R2 wake_req");
      expect_at(cyc + 1, 2, 1'b1, "R2 to_n");
      expect_at(cyc + 1, 3, 1'b1, "R2 pd_n");
      step(2);
      // R2: default period select of PRS ticks
      do_clr(); e0 = cyc;
      expect_timeout(e0, DIV * (1 << PRS), "R2 default period");
      wait_to(e0 + DIV * (1 << PRS) + 3);

      // R1 R6: select 2 and select 0
      load_ps(2);
      do_clr(); e0 = cyc;
      expect_at(e0 + 1, 2, 1'b1, "R8 clr sets to_n");
      expect_timeout(e0, DIV * 4, "R1 R6 select 2");
      wait_to(e0 + DIV * 4 + 3);
      load_ps(0);
      do_clr(); e0 = cyc;
      expect_timeout(e0, DIV, "R1 select 0");
      wait_to(e0 + DIV + 3);

      // R5: clear events push the time-out out
      load_ps(2);
      do_clr(); e0 = cyc;
      step(100);
      do_clr(); e1 = cyc;
      expect_at(e0 + DIV * 4, 0, 1'b0, "R5 clr_wdt restart");
      expect_timeout(e1, DIV * 4, "R5 clr_wdt restart");
      wait_to(e1 + DIV * 4 + 3);
      do_clr(); e0 = cyc;
      step(100);
      osc_fail = 1'b1; step(1); osc_fail = 1'b0; e1 = cyc;
      expect_at(e0 + DIV * 4, 0, 1'b0, "R5 osc_fail restart");
      expect_timeout(e1, DIV * 4, "R5 osc_fail restart");
      wait_to(e1 + DIV * 4 + 3);

      // R3: select above the ceiling acts as the ceiling
      load_ps(31);
      do_clr(); e0 = cyc;
      expect_at(e0 + DIV * (1 << PRS), 0, 1'b0, "R3 clamp");
      expect_timeout(e0, DIV * (1 << PMX), "R3 clamp");
      wait_to(e0 + DIV * (1 << PMX) + 3);

      // R4: disabled modes stay quiet, software enable starts counting
      load_ps(2);
      mode = 2'b00; e0 = cyc;
      expect_at(e0 + DIV * 4, 0, 1'b0, "R4 mode off");
      expect_at(e0 + DIV * 8, 0, 1'b0, "R4 mode off");
      step(300);
      mode = 2'b01; sw_en = 1'b0; e0 = cyc;
      expect_at(e0 + DIV * 4, 0, 1'b0, "R4 soft disabled");
      step(200);
      sw_en = 1'b1; e0 = cyc;
      expect_timeout(e0, DIV * 4, "R4 soft enabled");
      wait_to(e0 + DIV * 4 + 3);

      // R4 R8 R5: mode 10 stops in sleep, exit restarts
      mode = 2'b10;
      do_clr();
      sleep_enter = 1'b1; step(1); sleep_enter = 1'b0; e0 = cyc;
      expect_at(e0, 3, 1'b0, "R8 pd_n on sleep");
      expect_at(e0, 2, 1'b1, "R8 to_n on sleep");
      expect_at(e0 + DIV * 4, 0, 1'b0, "R4 awake-only sleeping");
      expect_at(e0 + DIV * 4, 1, 1'b0, "R4 awake-only sleeping");
      expect_at(e0 + DIV * 8, 1, 1'b0, "R4 awake-only sleeping");
      step(300);
      sleep_exit = 1'b1; step(1); sleep_exit = 1'b0; e1 = cyc;
      expect_timeout(e1, DIV * 4, "R5 sleep exit restart");
      expect_at(e1 + DIV * 4, 3, 1'b0, "R8 pd_n holds");
      wait_to(e1 + DIV * 4 + 3);

      // R7: always-on sleep time-out wakes instead of resetting
      mode = 2'b11;
      do_clr(); e0 = cyc;
      expect_at(e0, 2, 1'b1, "R8 clr flags");
      expect_at(e0, 3, 1'b1, "R8 clr flags");
      sleep_enter = 1'b1; step(1); sleep_enter = 1'b0; e0 = cyc;
      expect_at(e0 + DIV * 4 - 1, 1, 1'b0, "R7 wake");
      expect_at(e0 + DIV * 4,     1, 1'b1, "R7 wake");
      expect_at(e0 + DIV * 4,     0, 1'b0, "R7 no reset");
      expect_at(e0 + DIV * 4,     2, 1'b0, "R7 to_n");
      expect_at(e0 + DIV * 4 + 1, 1, 1'b0, "R7 wake");
      expect_timeout(e0 + DIV * 4, DIV * 4, "R7 awake after wake");
      wait_to(e0 + DIV * 8 + 3);

      // R8: clear and sleep entry together
      clr_wdt = 1'b1; sleep_enter = 1'b1; step(1);
      clr_wdt = 1'b0; sleep_enter = 1'b0; e0 = cyc;
      expect_at(e0, 3, 1'b0, "R8 enter wins");
      expect_at(e0, 2, 1'b1, "R8 enter wins");
      step(2);
      sleep_exit = 1'b1; step(1); sleep_exit = 1'b0;

      while (exp_q.size() > 0) step(1);
      step(2);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule